// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces the digital frequency-offset word for the fractional divider of a spread-spectrum clock synthesizer. The offset follows a triangular sweep. Its depth and its placement relative to the nominal frequency come from a 5-bit spread code. A low-rate step timer, derived from the reference clock, sets the pace of the sweep.

Two sources can drive the configuration. In pin mode, the spread enable comes from a latched pin and the depth is fixed at a 0.80 % down spread. In register mode, both the code and the enable come from register bits. A new configuration is taken only at the point of the sweep where the offset is zero, so a change never causes a frequency jump.

The offset is a signed word in units of 0.01 % × 2^SCALE_SH. For an amplitude A (in hundredths of a percent), the full sweep depth M is A·2^SCALE_SH.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `offset` is 0.
- R2: Amplitude A in hundredths of a percent, by code (as an unsigned number):
  - 0–7 and 24–31: 60, 80, 100, 125, 150, 200, 50, 100
  - 8–15: 60, 80, 100, 125, 150, 175, 200, 250
  - 16–23: 300, 30, 40, 50, 70, 100, 120, 150
- R3: Bit 3 of the active code selects the sweep type: 0 = down spread (offset never positive), 1 = center spread.
- R4: Down spread with phase p (0 ≤ p < 2H, H = 2^HALF_LOG2) gives offset −t·M/H, where t = p for p ≤ H and 2H−p otherwise. The sweep runs 0 → −M → 0, and successive offsets never differ by more than one step of M/H.
- R5: Center spread gives offset (H/2 − t')·M/H, where t' is the same triangle as in R4 taken at phase (p + H/2) mod 2H. The sweep runs 0 → −M/2 → 0 → +M/2 → 0.
- R6: The phase advances once every TICK = REF_HZ / (MOD_HZ·2H) clock cycles, so one sweep lasts 2H·TICK cycles. The first step comes TICK cycles after reset, and `offset` shows the new phase one cycle after each step.
- R7: With `sw_sel`=0, code 00001 (0.80 % down) and `pin_spread_en` are used, and `reg_code` and `reg_spread_en` have no effect. With `sw_sel`=1, `reg_code` and `reg_spread_en` are used and `pin_spread_en` has no effect.
- R8: With the active enable at 0, the phase stays at 0 and `offset` stays at 0.
- R9: The configuration is sampled only on a step where the phase is 0. A change made at any other time has no effect until that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_sel | input | 1 | 0: pin control, 1: register control |
| pin_spread_en | input | 1 | Latched spread-enable pin |
| reg_code | input | 5 | Register spread code |
| reg_spread_en | input | 1 | Register spread enable |
| offset | output | OW | Signed frequency-offset word |

## Verification
Count cycles from the first rising edge after reset release as c = 1, 2, …. Phase step k then lands on edge k·TICK. The configuration for sweep P is taken on edge (2H·P + 1)·TICK, and the offset sampled after edge c reflects the phase reached on edge c − 1.

The bench samples on the falling edge and derives every expected value from c alone, using these rules and the R2 table. The rules reduce to three quantities: the phase index, the sweep index and the configuration latch edge.

Mid-sweep changes are applied just after a chosen edge. The bench then decides old versus new configuration by comparing that edge with the latch edge of each sweep. This shows that nothing moves before the zero point.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int AMP_W = 9;
    localparam logic [4:0] PIN_DEFAULT_CODE = 5'b00001;

    typedef enum logic {
        SHAPE_DOWN   = 1'b0,
        SHAPE_CENTER = 1'b1
    } shape_e;

    typedef struct packed {
        logic             en;
        shape_e           shape;
        logic [AMP_W-1:0] amp;
    } prof_cfg_t;

    // Sweep depth in hundredths of a percent for each 5-bit code.
    function automatic logic [AMP_W-1:0] code_amp(input logic [4:0] code);
        logic [AMP_W-1:0] a;
        case (code[4:3])
            2'b10: begin
                case (code[2:0])
                    3'd0: a = 9'd300;
                    3'd1: a = 9'd30;
                    3'd2: a = 9'd40;
                    3'd3: a = 9'd50;
                    3'd4: a = 9'd70;
                    3'd5: a = 9'd100;
                    3'd6: a = 9'd120;
                    default: a = 9'd150;
                endcase
            end
            2'b01: begin
                case (code[2:0])
                    3'd0: a = 9'd60;
                    3'd1: a = 9'd80;
                    3'd2: a = 9'd100;
                    3'd3: a = 9'd125;
                    3'd4: a = 9'd150;
                    3'd5: a = 9'd175;
                    3'd6: a = 9'd200;
                    default: a = 9'd250;
                endcase
            end
            default: begin
                case (code[2:0])
                    3'd0: a = 9'd60;
                    3'd1: a = 9'd80;
                    3'd2: a = 9'd100;
                    3'd3: a = 9'd125;
                    3'd4: a = 9'd150;
                    3'd5: a = 9'd200;
                    3'd6: a = 9'd50;
                    default: a = 9'd100;
                endcase
            end
        endcase
        return a;
    endfunction

    function automatic prof_cfg_t decode_cfg(input logic [4:0] code, input logic en);
        prof_cfg_t c;
        c.en    = en;
        c.shape = code[3] ? SHAPE_CENTER : SHAPE_DOWN;
        c.amp   = code_amp(code);
        return c;
    endfunction

endpackage

// File: rtl/ssc_src_sel.sv
module ssc_src_sel
    import ssc_pkg::*;
(
    input  logic      sw_sel,
    input  logic      pin_spread_en,
    input  logic [4:0] reg_code,
    input  logic      reg_spread_en,
    output prof_cfg_t sel_cfg
);

    always_comb begin
        if (sw_sel)
            sel_cfg = decode_cfg(reg_code, reg_spread_en);
        else
            sel_cfg = decode_cfg(PIN_DEFAULT_CODE, pin_spread_en);
    end

endmodule

// File: rtl/ssc_step_timer.sv
module ssc_step_timer #(
    parameter int TICK = 7
) (
    input  logic clk,
    input  logic rst,
    output logic step_tick
);

    generate
        if (TICK <= 1) begin : g_every_cycle
            assign step_tick = 1'b1;
        end else begin : g_divider
            localparam int CW = $clog2(TICK);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (cnt == CW'(TICK - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + CW'(1);
            end

            assign step_tick = (cnt == CW'(TICK - 1));
        end
    endgenerate

endmodule

// File: rtl/ssc_phase_seq.sv
module ssc_phase_seq
    import ssc_pkg::*;
#(
    parameter int HALF_LOG2 = 5,
    localparam int PW = HALF_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_tick,
    input  prof_cfg_t     cfg_in,
    output logic [PW-1:0] phase,
    output prof_cfg_t     act_cfg
);

    // Phase spans 0..2H-1 and wraps naturally in PW bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            act_cfg <= '0;
        end else if (step_tick) begin
            if (phase == '0) begin
                act_cfg <= cfg_in;
                phase   <= cfg_in.en ? PW'(1) : '0;
            end else begin
                phase <= phase + PW'(1);
            end
        end
    end

endmodule

// File: rtl/ssc_offset_map.sv
module ssc_offset_map
    import ssc_pkg::*;
#(
    parameter int HALF_LOG2 = 5,
    parameter int SCALE_SH  = 8,
    parameter int OW        = 18,
    localparam int PW = HALF_LOG2 + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PW-1:0]        phase,
    input  prof_cfg_t            act_cfg,
    output logic signed [OW-1:0] offset
);

    localparam int HALF = 1 << HALF_LOG2;
    localparam int KW   = PW + 2;
    localparam int PRW  = OW + KW;
    localparam int SHD  = SCALE_SH - HALF_LOG2;

    logic [OW-1:0]         step_sz;
    logic [PW-1:0]         ph_rot;
    logic [PW:0]           ramp;
    logic signed [KW-1:0]  mult_k;
    logic signed [PRW-1:0] prod;

    always_comb begin
        step_sz = OW'(act_cfg.amp) << SHD;
        ph_rot  = (act_cfg.shape == SHAPE_CENTER) ? phase + PW'(HALF / 2) : phase;
        ramp    = (ph_rot <= PW'(HALF)) ? {1'b0, ph_rot}
                                        : (PW + 1)'(2 * HALF) - {1'b0, ph_rot};
        if (act_cfg.shape == SHAPE_CENTER)
            mult_k = KW'(HALF / 2) - KW'(ramp);
        else
            mult_k = KW'(0) - KW'(ramp);
        prod = mult_k * $signed({{KW{1'b0}}, step_sz});
    end

    always_ff @(posedge clk) begin
        if (rst)
            offset <= '0;
        else
            offset <= act_cfg.en ? OW'(prod) : '0;
    end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int REF_HZ    = 14_318_000,
    parameter int MOD_HZ    = 31_500,
    parameter int HALF_LOG2 = 5,
    parameter int SCALE_SH  = 8,
    localparam int OW = AMP_W + SCALE_SH + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sw_sel,
    input  logic                 pin_spread_en,
    input  logic [4:0]           reg_code,
    input  logic                 reg_spread_en,
    output logic signed [OW-1:0] offset
);

    localparam int HALF     = 1 << HALF_LOG2;
    localparam int PW       = HALF_LOG2 + 1;
    localparam int TICK     = REF_HZ / (MOD_HZ * 2 * HALF);
    localparam int MAX_STEP = 300 << (SCALE_SH - HALF_LOG2);

    prof_cfg_t     sel_cfg;
    prof_cfg_t     act_cfg;
    logic          step_tick;
    logic [PW-1:0] phase;

    ssc_src_sel u_src (
        .sw_sel        (sw_sel),
        .pin_spread_en (pin_spread_en),
        .reg_code      (reg_code),
        .reg_spread_en (reg_spread_en),
        .sel_cfg       (sel_cfg)
    );

    ssc_step_timer #(.TICK(TICK)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick)
    );

    ssc_phase_seq #(.HALF_LOG2(HALF_LOG2)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick),
        .cfg_in    (sel_cfg),
        .phase     (phase),
        .act_cfg   (act_cfg)
    );

    ssc_offset_map #(
        .HALF_LOG2 (HALF_LOG2),
        .SCALE_SH  (SCALE_SH),
        .OW        (OW)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .act_cfg (act_cfg),
        .offset  (offset)
    );

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
    import ssc_pkg::*;
#(
    parameter int PW      = 6,
    parameter int OW      = 18,
    parameter int MAXSTEP = 2400
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sw_sel,
    input logic                 step_tick,
    input logic [PW-1:0]        phase,
    input prof_cfg_t            act,
    input logic signed [OW-1:0] offset
);

    logic signed [OW-1:0] prev_off;
    int                   diff;

    always_ff @(posedge clk) begin
        if (rst)
            prev_off <= '0;
        else
            prev_off <= offset;
    end

    always_comb diff = int'(offset) - int'(prev_off);

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (offset == '0));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !act.en |=> (offset == '0));

    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != '0) |=> $stable(act));

    a_r9_zero_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |=> (offset == '0));

    a_r6_step_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> $stable(phase));

    a_r3_down_nonpositive: assert property (@(posedge clk) disable iff (rst)
        (act.shape == SHAPE_DOWN) |-> (offset <= 0));

    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (diff <= MAXSTEP) && (diff >= -MAXSTEP));

    a_r7_pin_default: assert property (@(posedge clk) disable iff (rst)
        (!sw_sel && step_tick && phase == '0) |=>
        (act.amp == AMP_W'(80) && act.shape == SHAPE_DOWN));

endmodule

bind ssc_profile_gen ssc_profile_chk #(
    .PW      (PW),
    .OW      (OW),
    .MAXSTEP (MAX_STEP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sw_sel    (sw_sel),
    .step_tick (step_tick),
    .phase     (phase),
    .act       (act_cfg),
    .offset    (offset)
);

// File: tb/ssc_profile_gen_test.sv
`timescale 1ns/1ps
module ssc_profile_gen_test;

    localparam int REF_B   = 800_000;
    localparam int MOD_B   = 25_000;
    localparam int HLOG_B  = 3;
    localparam int SCALE_B = 4;
    localparam int H_B     = 1 << HLOG_B;
    localparam int TICK_B  = REF_B / (MOD_B * 2 * H_B);
    localparam int OW_B    = 9 + SCALE_B + 1;
    localparam int NEVER   = 1_000_000;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   sw_sel = 1'b1;
    logic                   pin_spread_en = 1'b0;
    logic [4:0]             reg_code = 5'd0;
    logic                   reg_spread_en = 1'b0;
    logic signed [OW_B-1:0] offset;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ssc_profile_gen #(
        .REF_HZ    (REF_B),
        .MOD_HZ    (MOD_B),
        .HALF_LOG2 (HLOG_B),
        .SCALE_SH  (SCALE_B)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .sw_sel        (sw_sel),
        .pin_spread_en (pin_spread_en),
        .reg_code      (reg_code),
        .reg_spread_en (reg_spread_en),
        .offset        (offset)
    );

    // R2 table, hundredths of a percent
    function automatic int amp_b(input int code);
        int tab[32] = '{60, 80, 100, 125, 150, 200, 50, 100,
                        60, 80, 100, 125, 150, 175, 200, 250,
                        300, 30, 40, 50, 70, 100, 120, 150,
                        60, 80, 100, 125, 150, 200, 50, 100};
        return tab[code];
    endfunction

    function automatic int tri_b(input int p);
        return (p <= H_B) ? p : 2 * H_B - p;
    endfunction

    // R3/R4/R5 shape of the sweep for a given phase
    function automatic int shape_exp(input int ph, input int code, input bit en);
        int m;
        if (!en || ph == 0) return 0;
        m = amp_b(code) * (1 << SCALE_B);
        if (((code / 8) % 2) == 0)
            return -(tri_b(ph) * m) / H_B;
        return ((H_B / 2 - tri_b((ph + H_B / 2) % (2 * H_B))) * m) / H_B;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: offset actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit sw, input bit pin_en, input int code, input bit en);
        sw_sel        = sw;
        pin_spread_en = pin_en;
        reg_code      = code[4:0];
        reg_spread_en = en;
    endtask

    // Runs one scenario: configuration 0 from reset, configuration 1 applied
    // just after edge c_ch. Expected values come from cycle arithmetic (R6/R9).
    task automatic run_case(input string req,
                            input bit sw0, input bit pin0, input int code0, input bit en0,
                            input bit sw1, input bit pin1, input int code1, input bit en1,
                            input int c_ch, input int ncyc);
        int ecode0, ecode1;
        bit een0, een1;
        ecode0 = sw0 ? code0 : 1;
        een0   = sw0 ? en0 : pin0;
        ecode1 = sw1 ? code1 : 1;
        een1   = sw1 ? en1 : pin1;
        rst = 1'b1;
        drive(sw0, pin0, code0, en0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({req, " R1 in reset"}, int'(offset), 0);
        rst = 1'b0;
        for (int c = 1; c <= ncyc; c++) begin
            int k, ph, per, latch_edge, exp;
            @(posedge clk);
            @(negedge clk);
            k          = (c - 1) / TICK_B;
            ph         = k % (2 * H_B);
            per        = k / (2 * H_B);
            latch_edge = (per * 2 * H_B + 1) * TICK_B;
            if (latch_edge > c_ch)
                exp = shape_exp(ph, ecode1, een1);
            else
                exp = shape_exp(ph, ecode0, een0);
            chk(req, int'(offset), exp);
            if (c == c_ch) drive(sw1, pin1, code1, en1);
        end
    endtask

    initial begin
        // R2, R3, R4, R5, R6: every code under register control
        for (int code = 0; code < 32; code++) begin
            if (((code / 8) % 2) == 0)
                run_case("R2 R3 R4 R6 down", 1, 0, code, 1, 1, 0, code, 1, NEVER, 2 * H_B * TICK_B + 20);
            else
                run_case("R2 R3 R5 R6 center", 1, 0, code, 1, 1, 0, code, 1, NEVER, 2 * H_B * TICK_B + 20);
        end
        // R7: pin control ignores register inputs, uses 0.80 % down
        run_case("R7 pin default", 0, 1, 16, 0, 0, 1, 16, 0, NEVER, 40);
        // R7 R8: pin enable low wins over register enable
        run_case("R7 R8 pin disabled", 0, 0, 5, 1, 0, 0, 5, 1, NEVER, 40);
        // R8: register enable low
        run_case("R8 reg disabled", 1, 1, 16, 0, 1, 1, 16, 0, NEVER, 40);
        // R9: code change mid-sweep waits for the zero point
        run_case("R9 code change", 1, 0, 5, 1, 1, 0, 9, 1, 10, 80);
        // R8 R9: disable mid-sweep completes the sweep, then holds zero
        run_case("R8 R9 disable", 1, 0, 2, 1, 1, 0, 2, 0, 40, 100);
        // R7 R9: switch from register to pin control mid-sweep
        run_case("R7 R9 source switch", 1, 0, 16, 1, 0, 1, 16, 1, 20, 80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule